// File: doc/BRIEF.md
# Intel HEX Record Stream Parser

This block takes the text of an Intel HEX programming file one ASCII character at a time over a valid/ready input. It turns that text into binary bytes, each with a full 32-bit target address, and presents them on a valid/ready output. Within each record it reads the start mark, the byte count, the 16-bit load address, the record kind, the payload and the trailing checksum. It keeps the upper address half that type-04 records supply. It also watches for the end-of-file record, after which it goes quiet until the next reset. A flash programmer or loader sits downstream and only ever sees bytes from records that have already passed their checksum.

A record's payload is held in a 256-entry buffer while the record is parsed. When the checksum byte confirms the record, the buffer drains to the output. During the drain the input is stalled. A record that fails its checksum, carries a stray character or uses an unsupported kind is thrown away. In each of these cases the block raises a one-cycle error pulse.

States: HUNT (waiting for a start mark), COUNT, ADDR, TYPE, DATA, SUM, DRAIN and DONE. Transitions:
- HUNT→COUNT when `:` is taken.
- COUNT→ADDR after two hex digits.
- ADDR→TYPE after four hex digits.
- TYPE→DATA when the count is non-zero, TYPE→SUM when the count is zero, and TYPE→HUNT when the kind is rejected.
- DATA→SUM after the last payload byte.
- SUM→DRAIN for a good data record with payload, SUM→DONE for a good end record, and SUM→HUNT otherwise.
- DRAIN→HUNT after the last byte is accepted.
- From any state between COUNT and SUM, a non-hex character leads to HUNT, or to COUNT if that character is `:`.

Top module: `ihex_parser`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, eof_done is 0, all three error outputs are 0, and the upper address half is 0x0000.
- R2: Hex digits 0-9, A-F and a-f each give one 4-bit value. Two digits make one byte, high nibble first. out_data carries the binary byte, never an ASCII code.
- R3: Payload byte i of a type-00 record is emitted with out_addr = {upper half, (record address + i) mod 2^16}.
- R4: A type-04 record with count 2 and a good checksum sets the upper half to its two payload bytes, first byte high. That value is used by every later data record.
- R5: The checksum passes when the 8-bit sum of the count, both address bytes, the type, every payload byte and the checksum byte is 0x00. On failure err_sum pulses and none of the record's bytes are emitted.
- R6: No byte of a record is emitted before its checksum is taken. While bytes are pending on the output, in_ready is 0.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_addr stay unchanged.
- R8: A type-01 record with count 00 and a good checksum sets eof_done, which stays 1 until reset. After that, every input character is accepted and produces no output and no error.
- R9: err_type pulses when the type byte completes in any of these cases: the type is not 00, 01 or 04; the type is 01 with a non-zero count; or the type is 04 with a count other than 2. The record is then abandoned and the upper half is left unchanged.
- R10: Outside a record, every character other than `:` (CR, LF, space or anything else) is accepted and dropped without an error.
- R11: A non-hex character inside a record pulses err_char and abandons the record. If that character is `:`, a new record starts at it.
- R12: A type-00 record with count 00 and a good checksum emits nothing and raises no error.
- R13: Each error output is a single-cycle pulse, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input character is offered |
| in_ready | output | 1 | The parser can take a character |
| in_char | input | 8 | ASCII character |
| out_valid | output | 1 | A decoded byte is presented |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Decoded binary byte |
| out_addr | output | ADDR_W | Absolute address of the byte |
| eof_done | output | 1 | End record seen; input ignored from then on |
| err_char | output | 1 | Pulse: non-hex character inside a record |
| err_sum | output | 1 | Pulse: record checksum failed |
| err_type | output | 1 | Pulse: unsupported record kind or count |

## Verification
The checker monitors four properties on every cycle:
- the output holds steady under backpressure;
- successive accepted bytes of one drain step their low address by one;
- eof_done stays set, with no output or error behind it;
- the error pulses never overlap, and a checksum failure is never accompanied by output.

Other behaviours are only visible through the bench's scenarios, which compare each emitted byte and address against values the bench computes itself. These are:
- decoding of upper- and lower-case digits;
- the effect of type-04 records, including rejected ones, on later addresses;
- wrap of the low address half;
- dropping of records with a bad checksum or a bad character, including restart on an embedded `:`;
- silent handling of zero-length records;
- stalling of the input during drain.

// File: rtl/ihex_pkg.sv
package ihex_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_COUNT,
        ST_ADDR,
        ST_TYPE,
        ST_DATA,
        ST_SUM,
        ST_DRAIN,
        ST_DONE
    } ihex_state_e;

    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] RT_DATA  = 8'h00;
    localparam logic [7:0] RT_EOF   = 8'h01;
    localparam logic [7:0] RT_UPPER = 8'h04;

endpackage

// File: rtl/ihex_hexdig.sv
// ASCII to nibble decode: accepts 0-9, A-F, a-f.
module ihex_hexdig (
    input  logic [7:0] ch,
    output logic [3:0] nib,
    output logic       ok
);
    always_comb begin
        nib = 4'h0;
        ok  = 1'b0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            nib = ch[3:0];
            ok  = 1'b1;
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            nib = ch[3:0] + 4'd9;
            ok  = 1'b1;
        end
    end
endmodule

// File: rtl/ihex_recbuf.sv
// Record payload store: one write port, one asynchronous read port.
module ihex_recbuf #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ihex_parser.sv
module ihex_parser #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_char,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              eof_done,
    output logic              err_char,
    output logic              err_sum,
    output logic              err_type
);
    import ihex_pkg::*;

    localparam int CNT_W     = 8;
    localparam int LOW_W     = 16;
    localparam int UP_W      = ADDR_W - LOW_W;   // must not exceed LOW_W
    localparam int BUF_DEPTH = 1 << CNT_W;

    ihex_state_e      state_q, state_d;
    logic [3:0]       hi_nib_q;
    logic             have_hi_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LOW_W-1:0] rec_addr_q;
    logic [7:0]       rtype_q;
    logic [7:0]       csum_q;
    logic [LOW_W-1:0] ela_q;
    logic [UP_W-1:0]  upper_q;
    logic [CNT_W-1:0] rd_idx_q;
    logic             e_char_q, e_sum_q, e_type_q;

    logic [3:0]       nib;
    logic             is_hex;
    logic             is_colon;
    logic             take;
    logic             in_body;
    logic             byte_done;
    logic [7:0]       byte_val;
    logic [7:0]       sum_next;
    logic             sum_ok;
    logic             rd_last;
    logic             data_last;
    logic [7:0]       buf_rd;

    function automatic logic type_ok(input logic [7:0] t, input logic [CNT_W-1:0] n);
        return (t == RT_DATA) ||
               (t == RT_EOF   && n == '0) ||
               (t == RT_UPPER && n == CNT_W'(2));
    endfunction

    ihex_hexdig u_dig (
        .ch  (in_char),
        .nib (nib),
        .ok  (is_hex)
    );

    ihex_recbuf #(
        .DEPTH (BUF_DEPTH),
        .WIDTH (8)
    ) u_buf (
        .clk   (clk),
        .we    (byte_done && state_q == ST_DATA),
        .waddr (idx_q),
        .wdata (byte_val),
        .raddr (rd_idx_q),
        .rdata (buf_rd)
    );

    assign is_colon  = (in_char == CH_COLON);
    assign take      = in_valid && in_ready;
    assign in_body   = (state_q == ST_COUNT) || (state_q == ST_ADDR) || (state_q == ST_TYPE) ||
                       (state_q == ST_DATA)  || (state_q == ST_SUM);
    assign byte_done = take && in_body && is_hex && have_hi_q;
    assign byte_val  = {hi_nib_q, nib};
    assign sum_next  = csum_q + byte_val;
    assign sum_ok    = (sum_next == 8'h00);
    assign rd_last   = (rd_idx_q == cnt_q - CNT_W'(1));
    assign data_last = (idx_q == cnt_q - CNT_W'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (take && is_colon) state_d = ST_COUNT;
            end
            ST_COUNT, ST_ADDR, ST_TYPE, ST_DATA, ST_SUM: begin
                if (take && !is_hex) begin
                    state_d = is_colon ? ST_COUNT : ST_HUNT;
                end else if (byte_done) begin
                    if (state_q == ST_COUNT) begin
                        state_d = ST_ADDR;
                    end else if (state_q == ST_ADDR) begin
                        if (idx_q == CNT_W'(1)) state_d = ST_TYPE;
                    end else if (state_q == ST_TYPE) begin
                        if (!type_ok(byte_val, cnt_q)) state_d = ST_HUNT;
                        else if (cnt_q == '0)          state_d = ST_SUM;
                        else                           state_d = ST_DATA;
                    end else if (state_q == ST_DATA) begin
                        if (data_last) state_d = ST_SUM;
                    end else begin
                        if (!sum_ok)                                   state_d = ST_HUNT;
                        else if (rtype_q == RT_DATA && cnt_q != '0)    state_d = ST_DRAIN;
                        else if (rtype_q == RT_EOF)                    state_d = ST_DONE;
                        else                                           state_d = ST_HUNT;
                    end
                end
            end
            ST_DRAIN: begin
                if (out_ready && rd_last) state_d = ST_HUNT;
            end
            ST_DONE: state_d = ST_DONE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Field and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_nib_q   <= '0;
            have_hi_q  <= 1'b0;
            idx_q      <= '0;
            cnt_q      <= '0;
            rec_addr_q <= '0;
            rtype_q    <= '0;
            csum_q     <= '0;
            ela_q      <= '0;
            upper_q    <= '0;
            rd_idx_q   <= '0;
            e_char_q   <= 1'b0;
            e_sum_q    <= 1'b0;
            e_type_q   <= 1'b0;
        end else begin
            e_char_q <= 1'b0;
            e_sum_q  <= 1'b0;
            e_type_q <= 1'b0;
            if (take && (state_q == ST_HUNT) && is_colon) begin
                have_hi_q <= 1'b0;
                idx_q     <= '0;
                csum_q    <= '0;
            end else if (take && in_body && !is_hex) begin
                e_char_q  <= 1'b1;
                have_hi_q <= 1'b0;
                idx_q     <= '0;
                csum_q    <= '0;
            end else if (take && in_body) begin
                if (!have_hi_q) begin
                    hi_nib_q  <= nib;
                    have_hi_q <= 1'b1;
                end else begin
                    have_hi_q <= 1'b0;
                    csum_q    <= sum_next;
                    if (state_q == ST_COUNT) begin
                        cnt_q <= byte_val;
                        idx_q <= '0;
                    end else if (state_q == ST_ADDR) begin
                        rec_addr_q <= {rec_addr_q[7:0], byte_val};
                        idx_q      <= (idx_q == CNT_W'(1)) ? '0 : idx_q + CNT_W'(1);
                    end else if (state_q == ST_TYPE) begin
                        rtype_q <= byte_val;
                        idx_q   <= '0;
                        if (!type_ok(byte_val, cnt_q)) e_type_q <= 1'b1;
                    end else if (state_q == ST_DATA) begin
                        idx_q <= idx_q + CNT_W'(1);
                        ela_q <= {ela_q[7:0], byte_val};
                    end else begin
                        rd_idx_q <= '0;
                        if (!sum_ok)                 e_sum_q <= 1'b1;
                        else if (rtype_q == RT_UPPER) upper_q <= ela_q[UP_W-1:0];
                    end
                end
            end else if (state_q == ST_DRAIN && out_ready) begin
                rd_idx_q <= rd_idx_q + CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q != ST_DRAIN);
        out_valid = (state_q == ST_DRAIN);
        out_data  = buf_rd;
        out_addr  = {upper_q, rec_addr_q + {{(LOW_W-CNT_W){1'b0}}, rd_idx_q}};
        eof_done  = (state_q == ST_DONE);
        err_char  = e_char_q;
        err_sum   = e_sum_q;
        err_type  = e_type_q;
    end

endmodule

// File: rtl/ihex_parser_chk.sv
module ihex_parser_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic [ADDR_W-1:0] out_addr,
    input logic              eof_done,
    input logic              err_char,
    input logic              err_sum,
    input logic              err_type
);
    assert_err_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_char, err_sum, err_type}));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid || out_addr[15:0] == $past(out_addr[15:0]) + 16'd1));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eof_done |=> eof_done);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eof_done |-> (!out_valid && !err_char && !err_sum && !err_type));

    assert_no_out_on_bad_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum |-> !out_valid);
endmodule

bind ihex_parser ihex_parser_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_addr  (out_addr),
    .eof_done  (eof_done),
    .err_char  (err_char),
    .err_sum   (err_sum),
    .err_type  (err_type)
);

// File: tb/tb_ihex_parser.sv
module tb_ihex_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        out_ready = 1'b1;
    logic        in_ready, out_valid, eof_done, err_char, err_sum, err_type;
    logic [7:0]  out_data;
    logic [31:0] out_addr;

    always #2 clk = ~clk;   // 250 MHz

    ihex_parser dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr),
        .eof_done(eof_done), .err_char(err_char), .err_sum(err_sum), .err_type(err_type)
    );

    int total = 0, bad = 0;
    int n_char = 0, n_sum = 0, n_type = 0, n_out = 0;
    int overlap_viol = 0, multi_err = 0, hold_viol = 0;
    logic [39:0] expq[$];
    logic [7:0]  payload[256];
    logic [15:0] up_model = 16'h0000;
    bit          done_model = 0;
    bit          ready_toggle = 0;
    logic [7:0]  lfsr = 8'h5A;
    bit          prev_stall = 0;
    logic [39:0] prev_out = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Output ready pattern, changed away from the sampling edge
    always @(posedge clk) begin
        #1;
        if (ready_toggle) begin
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready <= lfsr[0] | lfsr[2];
        end else begin
            out_ready <= 1'b1;
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_char) n_char++;
            if (err_sum)  n_sum++;
            if (err_type) n_type++;
            if ($countones({err_char, err_sum, err_type}) > 1) multi_err++;
            if (out_valid && in_ready) overlap_viol++;
            if (prev_stall && !(out_valid && {out_addr, out_data} == prev_out)) hold_viol++;
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_addr, out_data};
            if (out_valid && out_ready) begin
                n_out++;
                if (expq.size() == 0) begin
                    check(1'b0, "R6 byte with nothing expected", {24'h0, out_addr, out_data}, 64'h0);
                end else begin
                    logic [39:0] e;
                    e = expq.pop_front();
                    check({out_addr, out_data} == e, "R2 R3 output byte", {24'h0, out_addr, out_data}, {24'h0, e});
                end
            end
        end
    end

    function automatic logic [7:0] hexch(input logic [3:0] v, input bit lc);
        if (v < 4'd10) return 8'h30 + {4'h0, v};
        return (lc ? 8'h61 : 8'h41) + {4'h0, v} - 8'd10;
    endfunction

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = c;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lc);
        send_char(hexch(b[7:4], lc));
        send_char(hexch(b[3:0], lc));
    endtask

    task automatic send_rec(input int n, input logic [15:0] a, input logic [7:0] t,
                            input bit corrupt, input bit lc);
        logic [7:0] s;
        s = 8'(n) + a[15:8] + a[7:0] + t;
        for (int i = 0; i < n; i++) s = s + payload[i];
        if (!done_model && !corrupt && t == 8'h00) begin
            for (int i = 0; i < n; i++) begin
                logic [15:0] lo;
                lo = a + 16'(i);
                expq.push_back({up_model, lo, payload[i]});
            end
        end
        send_char(8'h3A);
        send_byte(8'(n), lc);
        send_byte(a[15:8], lc);
        send_byte(a[7:0], lc);
        send_byte(t, lc);
        for (int i = 0; i < n; i++) send_byte(payload[i], lc);
        send_byte((8'h00 - s) ^ {7'h0, corrupt}, lc);
        send_char(8'h0D);
        send_char(8'h0A);
        if (!done_model && !corrupt && t == 8'h04 && n == 2) up_model = {payload[0], payload[1]};
        if (!corrupt && t == 8'h01 && n == 0) done_model = 1;
    endtask

    task automatic settle();
        @(negedge clk);
        while (out_valid) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) payload[i] = 8'(i * 7 + seed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int o, c, s, ty;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(eof_done == 1'b0, "R1 eof_done", eof_done, 0);
        check({err_char, err_sum, err_type} == 3'b000, "R1 errors", {err_char, err_sum, err_type}, 0);
        rst_n = 1'b1;

        // R4: no type-04 yet, upper half is zero; R2 upper-case digits
        fill(3);
        o = n_out;
        send_rec(16, 16'h0000, 8'h00, 0, 0);
        settle();
        check(n_out - o == 16, "R4 R6 first record count", n_out - o, 16);

        // R10: filler outside records; R2 lower-case digits
        fill(200);
        send_char(8'h20); send_char(8'h0D); send_char(8'h0A); send_char(8'h78);
        o = n_out;
        send_rec(8, 16'h1230, 8'h00, 0, 1);
        settle();
        check(n_char == 0, "R10 no error outside record", n_char, 0);
        check(n_out - o == 8, "R2 lower-case record count", n_out - o, 8);

        // R4 + R3: upper half 0x0001, low half wraps
        payload[0] = 8'h00; payload[1] = 8'h01;
        send_rec(2, 16'h0000, 8'h04, 0, 0);
        fill(91);
        o = n_out;
        send_rec(8, 16'hFFFC, 8'h00, 0, 0);
        settle();
        check(n_out - o == 8, "R3 wrap record count", n_out - o, 8);

        // R7 / R6: backpressure on the output
        ready_toggle = 1;
        fill(17);
        send_rec(32, 16'h0100, 8'h00, 0, 0);
        settle();
        ready_toggle = 0;
        repeat (3) @(negedge clk);
        check(hold_viol == 0, "R7 hold under backpressure", hold_viol, 0);
        check(overlap_viol == 0, "R6 input stalled during drain", overlap_viol, 0);

        // R5: bad checksum
        o = n_out; s = n_sum;
        fill(55);
        send_rec(8, 16'h0200, 8'h00, 1, 0);
        settle();
        check(n_sum - s == 1, "R5 checksum error pulse", n_sum - s, 1);
        check(n_out - o == 0, "R5 nothing emitted", n_out - o, 0);

        // R9: unsupported kinds; upper half stays 0x0001
        ty = n_type; o = n_out;
        send_rec(2, 16'h0000, 8'h02, 0, 0);
        payload[0] = 8'h77;
        send_rec(1, 16'h0000, 8'h04, 0, 0);
        payload[0] = 8'h00;
        send_rec(1, 16'h0000, 8'h01, 0, 0);
        settle();
        check(n_type - ty == 3, "R9 type error pulses", n_type - ty, 3);
        check(n_out - o == 0, "R9 nothing emitted", n_out - o, 0);
        fill(9);
        o = n_out;
        send_rec(4, 16'h0040, 8'h00, 0, 0);
        settle();
        check(n_out - o == 4, "R9 R4 upper half kept", n_out - o, 4);

        // R11: bad character inside record, then ':' restart
        c = n_char; o = n_out;
        send_char(8'h3A); send_char(8'h30); send_char(8'h34); send_char(8'h30); send_char(8'h30);
        send_char(8'h47); send_char(8'h31); send_char(8'h32); send_char(8'h0D); send_char(8'h0A);
        settle();
        check(n_char - c == 1, "R11 bad char pulse", n_char - c, 1);
        check(n_out - o == 0, "R11 record dropped", n_out - o, 0);
        c = n_char;
        send_char(8'h3A); send_char(8'h31); send_char(8'h30);
        fill(120);
        send_rec(16, 16'h0500, 8'h00, 0, 0);
        settle();
        check(n_char - c == 1, "R11 colon restart pulse", n_char - c, 1);
        check(n_out - o == 16, "R11 restarted record emitted", n_out - o, 16);

        // R12: zero-length data record
        o = n_out; c = n_char; s = n_sum; ty = n_type;
        send_rec(0, 16'h0300, 8'h00, 0, 0);
        settle();
        check(n_out - o == 0, "R12 nothing emitted", n_out - o, 0);
        check((n_char - c) + (n_sum - s) + (n_type - ty) == 0, "R12 no error", n_char - c, 0);

        // R3 / R6: full 255-byte record
        fill(1);
        o = n_out;
        send_rec(255, 16'h4000, 8'h00, 0, 0);
        settle();
        check(n_out - o == 255, "R3 R6 full record count", n_out - o, 255);

        // R8: end of file, then everything ignored
        send_rec(0, 16'h0000, 8'h01, 0, 0);
        settle();
        check(eof_done == 1'b1, "R8 done set", eof_done, 1);
        o = n_out; c = n_char; s = n_sum; ty = n_type;
        fill(33);
        send_rec(8, 16'h0600, 8'h00, 0, 0);
        send_char(8'h47);
        send_rec(2, 16'h0000, 8'h05, 0, 0);
        settle();
        check(n_out - o == 0, "R8 no output after done", n_out - o, 0);
        check((n_char - c) + (n_sum - s) + (n_type - ty) == 0, "R8 no error after done", n_char - c, 0);
        check(eof_done == 1'b1, "R8 done sticky", eof_done, 1);
        check(in_ready == 1'b1, "R8 input accepted", in_ready, 1);

        check(multi_err == 0, "R13 error pulses exclusive", multi_err, 0);
        check(expq.size() == 0, "R6 all expected bytes seen", expq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule